// File: doc/BRIEF.md
# Data RAM with In-Memory Pointer Registers

This unit is the data memory of a small 8-bit controller core. It holds 112 bytes of general RAM and a 16-byte register area. Three of the register bytes act as pointers: a primary pointer, an alternate pointer and a stack pointer. Because the pointers are ordinary bytes of the array, any command can read, write or bit-modify them. Indirect accesses can also step them up or down as a side effect of the access.

The core issues at most one command per clock on a flat command interface. The unit supports these commands:
- direct read and write
- read or write through a pointer, with optional post-step
- immediate load of a register byte
- decrement with a zero test
- set, clear or test of a single bit
- byte push and pop on the stack

Every command finishes in one cycle: the array is read combinationally and written at the clock edge. The response (a data byte and a flag) is registered and appears in the following cycle. Neither the array nor the pointer bytes are initialised by reset, so software must store a byte before it reads it.

Top module: `dmem_ptr_ram`

## Requirements
- R1: While reset is asserted and until the first command completes, rsp_valid, rsp_data and rsp_flag are all 0.
- R2: A direct write (op 2) followed by a direct read (op 1) returns the written byte, for addresses 0x00–0x6F and 0xF0–0xFF.
- R3: Addresses 0x70–0xEF are unmapped: reads from them return 0x00, and writes to them alter no mapped byte.
- R4: Opcodes: 0 no-op, 1 read, 2 write, 3 indirect read, 4 indirect write, 5 register load, 6 decrement-and-test, 7 bit set, 8 bit clear, 9 bit test, 10 push, 11 pop, and 12–15 behave as no-op. rsp_valid is 1 in the cycle after each command with opcode 1–11 and 0 otherwise.
- R5: The alternate pointer lives at 0xFC, the stack pointer at 0xFD and the primary pointer at 0xFE. An indirect access uses the current content of the pointer byte as its address.
- R6: cmd_ptr selects the primary pointer (0) or the alternate pointer (1). cmd_step selects the step: 0 none, 1 post-increment, 2 post-decrement, 3 none. A stepping indirect read uses the old pointer value as its address and leaves the pointer at old±1 modulo 256.
- R7: An indirect write stores cmd_wdata at the old pointer value and steps the pointer in the same way as R6.
- R8: If an indirect write with a step targets the pointer's own byte, the stepped value is what remains in that byte. Without a step, the written data remains.
- R9: Register load (op 5) writes cmd_wdata to 0xF0 + cmd_addr[3:0]. The upper address bits are ignored.
- R10: Decrement-and-test (op 6) on register 0xF0 + cmd_addr[3:0] writes back the old value minus 1, modulo 256, and returns it on rsp_data. rsp_flag is 1 exactly when that result is 0x00.
- R11: Bit set (op 7) and bit clear (op 8) modify bit cmd_bit of the byte at cmd_addr and return the new byte. This works for every mapped byte, including the pointers.
- R12: Bit test (op 9) returns the byte unchanged and sets rsp_flag to 1 exactly when bit cmd_bit is 0.
- R13: Push (op 10) writes cmd_wdata at the stack pointer and then decrements it. Pop (op 11) increments the stack pointer and returns the byte at the new value. A two-byte return address pushed low byte first therefore pops high byte first.
- R14: rsp_flag is 0 after every command other than decrement-and-test and bit test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the response register |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 4 | Command opcode (see R4) |
| cmd_addr | input | 8 | Direct address; low 4 bits give the register index for ops 5 and 6 |
| cmd_wdata | input | 8 | Write, load or push data |
| cmd_ptr | input | 1 | Pointer select for indirect ops: 0 primary, 1 alternate |
| cmd_step | input | 2 | Post-step for indirect ops: 0 none, 1 increment, 2 decrement |
| cmd_bit | input | 3 | Bit index for ops 7–9 |
| rsp_valid | output | 1 | Response of the previous cycle's command is valid |
| rsp_data | output | 8 | Read byte or result byte |
| rsp_flag | output | 1 | Zero flag (op 6) or bit-clear flag (op 9) |

## Verification
Two effects can land on the same byte in a single cycle. The first case is an indirect write through a pointer that currently holds its own address while a post-step is requested. The second is a push when the stack pointer holds 0xFD. The bench provokes the first case by loading 0xFE into the primary pointer and issuing a stepping indirect write. It then reads 0xFE directly and expects the stepped value rather than the data byte. It repeats the write without a step and expects the data byte to stay.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int DW = 8;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_RD   = 4'd1,
        OP_WR   = 4'd2,
        OP_RDI  = 4'd3,
        OP_WRI  = 4'd4,
        OP_LDI  = 4'd5,
        OP_DECT = 4'd6,
        OP_BSET = 4'd7,
        OP_BCLR = 4'd8,
        OP_BTST = 4'd9,
        OP_PUSH = 4'd10,
        OP_POP  = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_RSV  = 2'd3
    } step_e;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
        logic          flag;
    } rsp_t;

endpackage

// File: rtl/dmem_amap.sv
module dmem_amap #(
    parameter int              AW        = 8,
    parameter int              GEN_BYTES = 112,
    parameter int              REG_COUNT = 16,
    parameter logic [AW-1:0]   REG_BASE  = 8'hF0,
    parameter int              IDX_W     = 7
) (
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam logic [AW-1:0] GEN_END  = AW'(GEN_BYTES);
    localparam logic [AW-1:0] REG_LAST = AW'(int'(REG_BASE) + REG_COUNT - 1);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (addr < GEN_END) begin
            hit = 1'b1;
            idx = IDX_W'(addr);
        end else if (addr >= REG_BASE && addr <= REG_LAST) begin
            hit = 1'b1;
            idx = IDX_W'(GEN_BYTES) + IDX_W'(addr - REG_BASE);
        end
    end
endmodule

// File: rtl/dmem_alu.sv
module dmem_alu
    import dmem_pkg::*;
#(
    parameter int DW_P  = DW,
    parameter int BIT_W = $clog2(DW_P)
) (
    input  op_e              op,
    input  logic [DW_P-1:0]  rd,
    input  logic [DW_P-1:0]  wd,
    input  logic [BIT_W-1:0] bsel,
    output logic [DW_P-1:0]  res,
    output logic             flag
);
    logic [DW_P-1:0] mask;

    always_comb begin
        mask = DW_P'(1) << bsel;
        res  = rd;
        flag = 1'b0;
        case (op)
            OP_WR, OP_WRI, OP_LDI, OP_PUSH: res = wd;
            OP_DECT: begin
                res  = rd - DW_P'(1);
                flag = (res == '0);
            end
            OP_BSET: res = rd | mask;
            OP_BCLR: res = rd & ~mask;
            OP_BTST: flag = ~rd[bsel];
            default: ;
        endcase
    end
endmodule

// File: rtl/dmem_store.sv
module dmem_store #(
    parameter int DW_P  = 8,
    parameter int DEPTH = 128,
    parameter int IDX_W = 7,
    parameter int TAP_B = 126,
    parameter int TAP_X = 124,
    parameter int TAP_S = 125
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW_P-1:0]  rd_data,
    input  logic             w0_en,
    input  logic [IDX_W-1:0] w0_idx,
    input  logic [DW_P-1:0]  w0_data,
    input  logic             w1_en,
    input  logic [IDX_W-1:0] w1_idx,
    input  logic [DW_P-1:0]  w1_data,
    output logic [DW_P-1:0]  tap_b,
    output logic [DW_P-1:0]  tap_x,
    output logic [DW_P-1:0]  tap_s
);
    logic [DEPTH-1:0][DW_P-1:0] mem_d;
    logic [DEPTH-1:0][DW_P-1:0] mem_q;

    // the pointer-step port takes precedence over the data port
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (w1_en && w1_idx == IDX_W'(i)) begin
                mem_d[i] = w1_data;
            end else if (w0_en && w0_idx == IDX_W'(i)) begin
                mem_d[i] = w0_data;
            end else begin
                mem_d[i] = mem_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_idx];
    assign tap_b   = mem_q[TAP_B];
    assign tap_x   = mem_q[TAP_X];
    assign tap_s   = mem_q[TAP_S];
endmodule

// File: rtl/dmem_ptr_ram.sv
module dmem_ptr_ram
    import dmem_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            GEN_BYTES = 112,
    parameter int            REG_COUNT = 16,
    parameter logic [AW-1:0] REG_BASE  = 8'hF0,
    parameter int            X_OFS     = 12,
    parameter int            SP_OFS    = 13,
    parameter int            B_OFS     = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [3:0]      cmd_op,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [DW-1:0]   cmd_wdata,
    input  logic            cmd_ptr,
    input  logic [1:0]      cmd_step,
    input  logic [2:0]      cmd_bit,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic            rsp_flag
);
    localparam int DEPTH  = GEN_BYTES + REG_COUNT;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int ROFS_W = $clog2(REG_COUNT);
    localparam logic [IDX_W-1:0] IDX_B = IDX_W'(GEN_BYTES + B_OFS);
    localparam logic [IDX_W-1:0] IDX_X = IDX_W'(GEN_BYTES + X_OFS);
    localparam logic [IDX_W-1:0] IDX_S = IDX_W'(GEN_BYTES + SP_OFS);

    op_e               op_w;
    logic              is_cmd;
    logic [DW-1:0]     ptr_b, ptr_x, ptr_sp;
    logic [DW-1:0]     sel_val;
    logic [IDX_W-1:0]  sel_idx;
    logic [AW-1:0]     tgt_addr;
    logic              tgt_hit;
    logic [IDX_W-1:0]  tgt_idx;
    logic              data_wr;
    logic              step_en;
    logic [IDX_W-1:0]  step_idx;
    logic [DW-1:0]     step_val;
    logic [DW-1:0]     rd_raw, rd_byte;
    logic [DW-1:0]     alu_res;
    logic              alu_flag;
    logic              w0_en, w1_en;
    rsp_t              rsp_d, rsp_q;

    assign op_w   = op_e'(cmd_op);
    assign is_cmd = cmd_valid && (cmd_op >= 4'(OP_RD)) && (cmd_op <= 4'(OP_POP));

    // target address and pointer-step selection
    always_comb begin
        sel_val  = cmd_ptr ? ptr_x : ptr_b;
        sel_idx  = cmd_ptr ? IDX_X : IDX_B;
        tgt_addr = cmd_addr;
        data_wr  = 1'b0;
        step_en  = 1'b0;
        step_idx = sel_idx;
        step_val = sel_val;
        case (op_w)
            OP_WR, OP_BSET, OP_BCLR: data_wr = 1'b1;
            OP_RDI, OP_WRI: begin
                tgt_addr = sel_val;
                data_wr  = (op_w == OP_WRI);
                if (cmd_step == STEP_INC) begin
                    step_en  = 1'b1;
                    step_val = sel_val + DW'(1);
                end else if (cmd_step == STEP_DEC) begin
                    step_en  = 1'b1;
                    step_val = sel_val - DW'(1);
                end
            end
            OP_LDI, OP_DECT: begin
                tgt_addr = REG_BASE + AW'(cmd_addr[ROFS_W-1:0]);
                data_wr  = 1'b1;
            end
            OP_PUSH: begin
                tgt_addr = ptr_sp;
                data_wr  = 1'b1;
                step_en  = 1'b1;
                step_idx = IDX_S;
                step_val = ptr_sp - DW'(1);
            end
            OP_POP: begin
                tgt_addr = ptr_sp + DW'(1);
                step_en  = 1'b1;
                step_idx = IDX_S;
                step_val = ptr_sp + DW'(1);
            end
            default: ;
        endcase
    end

    dmem_amap #(
        .AW(AW), .GEN_BYTES(GEN_BYTES), .REG_COUNT(REG_COUNT),
        .REG_BASE(REG_BASE), .IDX_W(IDX_W)
    ) u_amap (
        .addr(tgt_addr), .hit(tgt_hit), .idx(tgt_idx)
    );

    assign rd_byte = tgt_hit ? rd_raw : '0;
    assign w0_en   = is_cmd && data_wr && tgt_hit;
    assign w1_en   = is_cmd && step_en;

    dmem_alu #(.DW_P(DW)) u_alu (
        .op(op_w), .rd(rd_byte), .wd(cmd_wdata), .bsel(cmd_bit),
        .res(alu_res), .flag(alu_flag)
    );

    dmem_store #(
        .DW_P(DW), .DEPTH(DEPTH), .IDX_W(IDX_W),
        .TAP_B(GEN_BYTES + B_OFS), .TAP_X(GEN_BYTES + X_OFS),
        .TAP_S(GEN_BYTES + SP_OFS)
    ) u_store (
        .clk(clk),
        .rd_idx(tgt_idx), .rd_data(rd_raw),
        .w0_en(w0_en), .w0_idx(tgt_idx), .w0_data(alu_res),
        .w1_en(w1_en), .w1_idx(step_idx), .w1_data(step_val),
        .tap_b(ptr_b), .tap_x(ptr_x), .tap_s(ptr_sp)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = is_cmd;
        if (is_cmd) begin
            rsp_d.data = alu_res;
            rsp_d.flag = alu_flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_data  = rsp_q.data;
    assign rsp_flag  = rsp_q.flag;
endmodule

// File: rtl/dmem_ptr_ram_chk.sv
module dmem_ptr_ram_chk
    import dmem_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            GEN_BYTES = 112,
    parameter logic [AW-1:0] REG_BASE  = 8'hF0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [3:0]    cmd_op,
    input logic [AW-1:0] cmd_addr,
    input logic          cmd_ptr,
    input logic [1:0]    cmd_step,
    input logic [2:0]    cmd_bit,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          rsp_flag,
    input logic [DW-1:0] ptr_b,
    input logic [DW-1:0] ptr_x,
    input logic [DW-1:0] ptr_sp
);
    localparam logic [AW-1:0] GEN_END = AW'(GEN_BYTES);

    logic known_op, ind_op, quiet_op;
    assign known_op = cmd_valid && cmd_op >= 4'(OP_RD) && cmd_op <= 4'(OP_POP);
    assign ind_op   = cmd_valid && (cmd_op == 4'(OP_RDI) || cmd_op == 4'(OP_WRI));
    assign quiet_op = cmd_valid && cmd_op != 4'(OP_NOP) && known_op
                      && cmd_op != 4'(OP_DECT) && cmd_op != 4'(OP_BTST);

    assert_rsp_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        known_op |=> rsp_valid);
    assert_rsp_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |=> !rsp_valid);
    assert_step_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_op && cmd_step == 2'(STEP_INC)) |=>
        (($past(cmd_ptr) ? ptr_x : ptr_b) == ($past(cmd_ptr ? ptr_x : ptr_b) + DW'(1))));
    assert_step_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_op && cmd_step == 2'(STEP_DEC)) |=>
        (($past(cmd_ptr) ? ptr_x : ptr_b) == ($past(cmd_ptr ? ptr_x : ptr_b) - DW'(1))));
    assert_push_sp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'(OP_PUSH)) |=> ptr_sp == $past(ptr_sp) - DW'(1));
    assert_pop_sp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'(OP_POP)) |=> ptr_sp == $past(ptr_sp) + DW'(1));
    assert_dect_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'(OP_DECT)) |=> rsp_flag == (rsp_data == '0));
    assert_btst_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'(OP_BTST)) |=> rsp_flag == !rsp_data[$past(cmd_bit)]);
    assert_flag_low_R14: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_op |=> !rsp_flag);
    assert_unmapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'(OP_RD) && cmd_addr >= GEN_END && cmd_addr < REG_BASE)
        |=> rsp_data == '0);
endmodule

bind dmem_ptr_ram dmem_ptr_ram_chk #(
    .AW(AW), .GEN_BYTES(GEN_BYTES), .REG_BASE(REG_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_ptr(cmd_ptr), .cmd_step(cmd_step),
    .cmd_bit(cmd_bit), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_flag(rsp_flag), .ptr_b(ptr_b), .ptr_x(ptr_x), .ptr_sp(ptr_sp)
);

// File: tb/sim_dmem_ptr_ram.sv
module sim_dmem_ptr_ram;
    import dmem_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [7:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       cmd_ptr = 1'b0;
    logic [1:0] cmd_step = '0;
    logic [2:0] cmd_bit = '0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       rsp_flag;

    int checks = 0;
    int errors = 0;
    logic       r_v;
    logic [7:0] r_d;
    logic       r_f;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmem_ptr_ram u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ptr(cmd_ptr),
        .cmd_step(cmd_step), .cmd_bit(cmd_bit), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_flag(rsp_flag)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic [7:0] wd,
                         input logic p, input logic [1:0] st, input logic [2:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
        cmd_ptr = p; cmd_step = st; cmd_bit = b;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        r_v = rsp_valid; r_d = rsp_data; r_f = rsp_flag;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        issue(OP_WR, a, d, 1'b0, 2'd0, 3'd0);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp_v);
        issue(OP_RD, a, 8'h00, 1'b0, 2'd0, 3'd0);
        chk(req, r_d, exp_v);
    endtask

    task automatic t_reset;
        chk("R1 valid", rsp_valid, 0);
        chk("R1 data", rsp_data, 0);
        chk("R1 flag", rsp_flag, 0);
    endtask

    task automatic t_direct;
        wr(8'h00, 8'h11); wr(8'h6F, 8'h22); wr(8'hF0, 8'h33); wr(8'hFF, 8'h44);
        rd_chk("R2 0x00", 8'h00, 8'h11);
        chk("R4 valid after read", r_v, 1);
        rd_chk("R2 0x6F", 8'h6F, 8'h22);
        rd_chk("R2 0xF0", 8'hF0, 8'h33);
        rd_chk("R2 0xFF", 8'hFF, 8'h44);
        issue(OP_NOP, 8'h00, 8'h00, 1'b0, 2'd0, 3'd0);
        chk("R4 nop no valid", r_v, 0);
        issue(4'd13, 8'h00, 8'h00, 1'b0, 2'd0, 3'd0);
        chk("R4 reserved no valid", r_v, 0);
    endtask

    task automatic t_unmapped;
        wr(8'h70, 8'hAA); wr(8'hEF, 8'hBB);
        rd_chk("R3 read 0x70", 8'h70, 8'h00);
        rd_chk("R3 read 0xEF", 8'hEF, 8'h00);
        rd_chk("R3 read 0x80", 8'h80, 8'h00);
        rd_chk("R3 0x00 kept", 8'h00, 8'h11);
        rd_chk("R3 0xF0 kept", 8'hF0, 8'h33);
    endtask

    task automatic t_pointers;
        wr(8'hFE, 8'h10); wr(8'h10, 8'h5A);
        wr(8'hFC, 8'h20); wr(8'h20, 8'hA5);
        issue(OP_RDI, 8'h00, 8'h00, 1'b0, STEP_NONE, 3'd0);
        chk("R5 read via primary", r_d, 8'h5A);
        issue(OP_RDI, 8'h00, 8'h00, 1'b1, STEP_NONE, 3'd0);
        chk("R5 read via alternate", r_d, 8'hA5);
        rd_chk("R5 primary unchanged", 8'hFE, 8'h10);
    endtask

    task automatic t_step;
        wr(8'h11, 8'h77);
        issue(OP_RDI, 8'h00, 8'h00, 1'b0, STEP_INC, 3'd0);
        chk("R6 inc uses old address", r_d, 8'h5A);
        rd_chk("R6 primary incremented", 8'hFE, 8'h11);
        issue(OP_RDI, 8'h00, 8'h00, 1'b0, STEP_DEC, 3'd0);
        chk("R6 dec uses old address", r_d, 8'h77);
        rd_chk("R6 primary decremented", 8'hFE, 8'h10);
        wr(8'hFE, 8'hFF);
        issue(OP_RDI, 8'h00, 8'h00, 1'b0, STEP_INC, 3'd0);
        chk("R6 read at 0xFF", r_d, 8'h44);
        rd_chk("R6 wrap up to 0x00", 8'hFE, 8'h00);
        wr(8'hFC, 8'h00);
        issue(OP_RDI, 8'h00, 8'h00, 1'b1, STEP_DEC, 3'd0);
        chk("R6 alt read at 0x00", r_d, 8'h11);
        rd_chk("R6 wrap down to 0xFF", 8'hFC, 8'hFF);
    endtask

    task automatic t_wri;
        wr(8'hFC, 8'h30);
        issue(OP_WRI, 8'h00, 8'h9C, 1'b1, STEP_INC, 3'd0);
        rd_chk("R7 written at old", 8'h30, 8'h9C);
        rd_chk("R7 alt incremented", 8'hFC, 8'h31);
        issue(OP_WRI, 8'h00, 8'h3D, 1'b1, STEP_DEC, 3'd0);
        rd_chk("R7 written at 0x31", 8'h31, 8'h3D);
        rd_chk("R7 alt decremented", 8'hFC, 8'h30);
    endtask

    task automatic t_collide;
        wr(8'hFE, 8'hFE);
        issue(OP_WRI, 8'h00, 8'h55, 1'b0, STEP_INC, 3'd0);
        chk("R8 response data", r_d, 8'h55);
        rd_chk("R8 step wins", 8'hFE, 8'hFF);
        wr(8'hFE, 8'hFE);
        issue(OP_WRI, 8'h00, 8'h42, 1'b0, STEP_NONE, 3'd0);
        rd_chk("R8 no step keeps data", 8'hFE, 8'h42);
    endtask

    task automatic t_ldi;
        issue(OP_LDI, 8'h03, 8'h66, 1'b0, 2'd0, 3'd0);
        rd_chk("R9 load 0xF3", 8'hF3, 8'h66);
        issue(OP_LDI, 8'h9A, 8'h67, 1'b0, 2'd0, 3'd0);
        rd_chk("R9 upper bits ignored", 8'hFA, 8'h67);
    endtask

    task automatic t_dect;
        issue(OP_LDI, 8'h05, 8'h02, 1'b0, 2'd0, 3'd0);
        issue(OP_DECT, 8'h05, 8'h00, 1'b0, 2'd0, 3'd0);
        chk("R10 2->1 data", r_d, 8'h01);
        chk("R10 2->1 flag", r_f, 0);
        issue(OP_DECT, 8'h05, 8'h00, 1'b0, 2'd0, 3'd0);
        chk("R10 1->0 data", r_d, 8'h00);
        chk("R10 1->0 flag", r_f, 1);
        issue(OP_DECT, 8'h05, 8'h00, 1'b0, 2'd0, 3'd0);
        chk("R10 0->FF data", r_d, 8'hFF);
        chk("R10 0->FF flag", r_f, 0);
        rd_chk("R10 stored", 8'hF5, 8'hFF);
    endtask

    task automatic t_bits;
        wr(8'h40, 8'h00);
        issue(OP_BSET, 8'h40, 8'h00, 1'b0, 2'd0, 3'd7);
        chk("R11 set bit7", r_d, 8'h80);
        issue(OP_BSET, 8'h40, 8'h00, 1'b0, 2'd0, 3'd0);
        chk("R11 set bit0", r_d, 8'h81);
        chk("R14 flag after set", r_f, 0);
        issue(OP_BCLR, 8'h40, 8'h00, 1'b0, 2'd0, 3'd7);
        chk("R11 clear bit7", r_d, 8'h01);
        rd_chk("R11 stored", 8'h40, 8'h01);
        wr(8'hFE, 8'h40);
        issue(OP_BSET, 8'hFE, 8'h00, 1'b0, 2'd0, 3'd0);
        wr(8'h41, 8'hC3);
        issue(OP_RDI, 8'h00, 8'h00, 1'b0, STEP_NONE, 3'd0);
        chk("R11 pointer bit set", r_d, 8'hC3);
    endtask

    task automatic t_btst;
        wr(8'h50, 8'hA5);
        issue(OP_BTST, 8'h50, 8'h00, 1'b0, 2'd0, 3'd0);
        chk("R12 bit0 one", r_f, 0);
        chk("R12 data", r_d, 8'hA5);
        issue(OP_BTST, 8'h50, 8'h00, 1'b0, 2'd0, 3'd6);
        chk("R12 bit6 zero", r_f, 1);
        rd_chk("R12 unchanged", 8'h50, 8'hA5);
        chk("R14 flag after read", r_f, 0);
        issue(OP_BTST, 8'h50, 8'h00, 1'b0, 2'd0, 3'd1);
        chk("R12 bit1 zero", r_f, 1);
        issue(OP_BTST, 8'h50, 8'h00, 1'b0, 2'd0, 3'd7);
        chk("R12 bit7 one", r_f, 0);
    endtask

    task automatic t_stack;
        wr(8'hFD, 8'h60);
        issue(OP_PUSH, 8'h00, 8'h34, 1'b0, 2'd0, 3'd0);
        issue(OP_PUSH, 8'h00, 8'h12, 1'b0, 2'd0, 3'd0);
        rd_chk("R13 sp after pushes", 8'hFD, 8'h5E);
        rd_chk("R13 low byte at 0x60", 8'h60, 8'h34);
        rd_chk("R13 high byte at 0x5F", 8'h5F, 8'h12);
        issue(OP_POP, 8'h00, 8'h00, 1'b0, 2'd0, 3'd0);
        chk("R13 pop high first", r_d, 8'h12);
        chk("R14 flag after pop", r_f, 0);
        issue(OP_POP, 8'h00, 8'h00, 1'b0, 2'd0, 3'd0);
        chk("R13 pop low second", r_d, 8'h34);
        rd_chk("R13 sp restored", 8'hFD, 8'h60);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_direct();
        t_unmapped();
        t_pointers();
        t_step();
        t_wri();
        t_collide();
        t_ldi();
        t_dect();
        t_bits();
        t_btst();
        t_stack();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule